// File: doc/BRIEF.md
# External Bus Chip-Select Timing Controller

This block runs single, non-burst accesses to one device on a local parallel bus. A requester presents an address, a direction and write data. The controller then steps through the bus phases. In multiplexed mode it first drives the address on the shared address/data lines and pulses the address-latch strobe. It holds the address through an isolation gap, then asserts chip-select for the data tenure. In non-multiplexed mode it skips straight to the chip-select phase, and the address appears on a dedicated address output.

Chip-select lasts two fixed clocks plus a programmable wait-state count. When acknowledge is enabled, the external device may pull its active-low acknowledge line low to end the wait states early. It can never cut into the two fixed clocks. On completion the controller pulses `done` for one clock. For a read it returns the data sampled on the last chip-select clock, zero-extended to the configured device width. The configuration inputs are captured when a request is accepted, so later changes do not affect a transfer that is already running.

Top module: `xbus_cs_ctrl`

## Requirements
- R1: While reset is asserted and after it is released: `bus_cs_n`=1, `done`=0, `err`=0, `req_ready`=1, `bus_ale`=0, `bus_ad_oe`=0 and `rdata`=0.
- R2: Without an accepted acknowledge, chip-select stays low for exactly 2 + `cfg_wait` consecutive clocks (wait 4 gives 6, wait 15 gives 17).
- R3: With `cfg_ack_en`=1, `bus_ack_n` sampled low in chip-select clock j (counting from 0) makes that clock the last one when j ≥ 1. Acknowledge seen in clock 0 takes effect in clock 1, so chip-select always lasts at least 2 clocks. An acknowledge that arrives after the wait period has no effect.
- R4: With `cfg_ack_en`=0, `bus_ack_n` is ignored and chip-select lasts the full 2 + `cfg_wait` clocks.
- R5: With `cfg_mux`=1, ALE is active for `cfg_ale_len`+1 clocks (code 0..3 gives 1..4). It is followed by an isolation gap of the same length with ALE inactive and chip-select high. Chip-select asserts in the next clock. Throughout ALE and the gap, `bus_ad_oe`=1 and `bus_ad_out` carries the address.
- R6: `cfg_ale_pol`=1 makes ALE active high and 0 makes it active low. Outside the ALE phase the line rests at the inactive level.
- R7: With `cfg_mux`=0, ALE is never active. Chip-select asserts in the clock right after acceptance, and `bus_addr` holds the request address during the access.
- R8: When `cfg_en`=0, an accepted request produces `done`=1 with `err`=1 in the next clock, and chip-select never asserts.
- R9: A request with `cfg_dsize`=2'b10 (reserved) produces `done`=1 with `err`=1 in the next clock. Chip-select, ALE and `bus_ad_oe` stay inactive.
- R10: Size codes are 00 = 1 byte, 01 = 2 bytes and 11 = 4 bytes. A read returns the low 8, 16 or 32 bits of `bus_ad_in` sampled on the last chip-select clock, zero-extended. During chip-select a write drives the same-masked write data with `bus_ad_oe`=1, and a read keeps `bus_ad_oe`=0.
- R11: `done` lasts one clock, with chip-select high and `err`=0 on success. `req_ready` is low from acceptance until `done` has ended.
- R12: The configuration inputs, including `cfg_wait` and `cfg_mux`, are captured at acceptance. Changing them during a transfer does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Chip-select enable |
| cfg_mux | input | 1 | 1 = multiplexed address/data |
| cfg_ale_pol | input | 1 | ALE active level |
| cfg_ale_len | input | 2 | ALE width and isolation gap, code+1 clocks |
| cfg_ack_en | input | 1 | Allow acknowledge to end wait states |
| cfg_dsize | input | 2 | Device width code |
| cfg_wait | input | WW | Wait-state count |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Idle, request accepted this clock |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Rejected request, valid with done |
| rdata | output | DW | Read data |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_ale | output | 1 | Address-latch strobe |
| bus_addr | output | AW | Dedicated address output |
| bus_ad_out | output | DW | Shared address/data drive value |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_out |
| bus_ad_in | input | DW | Shared lines, input side |
| bus_ack_n | input | 1 | Device acknowledge, active low |

## Verification
The chip-select timing is tried with acknowledge arriving in the first clock, in a middle clock, after the wait period, never, and while disabled. Comparing the measured lengths separates the fixed floor, the early cut and the ignored case. The multiplexed patterns use every ALE polarity and several length codes, so ALE width, gap width and chip-select latency are each checked against the code. Reads at each size and writes at two sizes show the masking and the drive enable. Rejected requests, a configuration change during a transfer, and checks that `done` lasts one clock cover the remaining paths.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    XB_IDLE,
    XB_ALE,
    XB_ISO,
    XB_CS,
    XB_RESP
  } xbus_state_e;

  typedef struct packed {
    logic       mux;
    logic       ale_pol;
    logic [1:0] ale_len;
    logic       ack_en;
    logic [1:0] dsize;
  } xbus_cfg_t;

  localparam logic [1:0] XB_DSIZE_RSVD = 2'b10;

endpackage

// File: rtl/xbus_phase_timer.sv
module xbus_phase_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          zero
);

  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (ld)       cnt_d = ld_val;
    else if (dec) cnt_d = cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign zero = (cnt == '0);

  // R2: the sequencer never counts a phase down past its end
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !zero);

endmodule

// File: rtl/xbus_ad_path.sv
module xbus_ad_path #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          write_in,
  input  logic [1:0]    dsize,
  input  logic          addr_phase,
  input  logic          data_phase,
  input  logic          cap,
  input  logic [DW-1:0] ad_in,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [DW-1:0] rdata
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          write_q;
  logic [DW-1:0] lane_mask;
  logic [DW-1:0] rdata_d;
  int unsigned   nbits;

  always_comb begin
    case (dsize)
      2'b00:   nbits = 8;
      2'b01:   nbits = 16;
      default: nbits = 32;
    endcase
    for (int i = 0; i < DW; i++) lane_mask[i] = (i < int'(nbits));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
    end else if (ld) begin
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
      write_q <= write_in;
    end
  end

  always_comb begin
    rdata_d = rdata;
    if (cap) rdata_d = ad_in & lane_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

  assign bus_addr = addr_q;
  assign ad_oe    = addr_phase | (data_phase & write_q);
  assign ad_out   = addr_phase ? DW'(addr_q) : (wdata_q & lane_mask);

  // R10: a read data tenure never drives the shared lines
  a_r10_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && !write_q) |-> !ad_oe);

endmodule

// File: rtl/xbus_cs_ctrl.sv
module xbus_cs_ctrl
  import xbus_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_mux,
  input  logic          cfg_ale_pol,
  input  logic [1:0]    cfg_ale_len,
  input  logic          cfg_ack_en,
  input  logic [1:0]    cfg_dsize,
  input  logic [WW-1:0] cfg_wait,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rdata,
  output logic          bus_cs_n,
  output logic          bus_ale,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_ad_out,
  output logic          bus_ad_oe,
  input  logic [DW-1:0] bus_ad_in,
  input  logic          bus_ack_n
);

  localparam int CW = WW + 1;

  xbus_state_e   state_q, state_d;
  xbus_cfg_t     cfg_q, cfg_live;
  logic [WW-1:0] wait_q;
  logic          err_q, err_d;
  logic          idle, accept, cs_last, cap;
  logic          tmr_ld, tmr_dec, tmr_zero;
  logic [CW-1:0] tmr_val, tmr_cnt;

  assign idle   = (state_q == XB_IDLE);
  assign accept = idle & req_valid;

  assign cfg_live = '{mux: cfg_mux, ale_pol: cfg_ale_pol, ale_len: cfg_ale_len,
                      ack_en: cfg_ack_en, dsize: cfg_dsize};

  // Acknowledge may only end the access once the fixed floor has passed.
  assign cs_last = tmr_zero |
                   (cfg_q.ack_en & ~bus_ack_n & (tmr_cnt <= {1'b0, wait_q}));

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    tmr_ld  = 1'b0;
    tmr_dec = 1'b0;
    tmr_val = '0;
    cap     = 1'b0;
    case (state_q)
      XB_IDLE: begin
        if (req_valid) begin
          if (!cfg_en || cfg_dsize == XB_DSIZE_RSVD) begin
            state_d = XB_RESP;
            err_d   = 1'b1;
          end else begin
            err_d  = 1'b0;
            tmr_ld = 1'b1;
            if (cfg_mux) begin
              state_d = XB_ALE;
              tmr_val = CW'(cfg_ale_len);
            end else begin
              state_d = XB_CS;
              tmr_val = CW'(cfg_wait) + CW'(1);
            end
          end
        end
      end
      XB_ALE: begin
        if (tmr_zero) begin
          state_d = XB_ISO;
          tmr_ld  = 1'b1;
          tmr_val = CW'(cfg_q.ale_len);
        end else begin
          tmr_dec = 1'b1;
        end
      end
      XB_ISO: begin
        if (tmr_zero) begin
          state_d = XB_CS;
          tmr_ld  = 1'b1;
          tmr_val = CW'(wait_q) + CW'(1);
        end else begin
          tmr_dec = 1'b1;
        end
      end
      XB_CS: begin
        if (cs_last) begin
          state_d = XB_RESP;
          cap     = 1'b1;
        end else begin
          tmr_dec = 1'b1;
        end
      end
      XB_RESP: state_d = XB_IDLE;
      default: state_d = XB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XB_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  // Configuration follows the inputs while idle and freezes at acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{mux: 1'b0, ale_pol: 1'b1, ale_len: 2'b00, ack_en: 1'b0, dsize: 2'b00};
      wait_q <= '0;
    end else if (idle) begin
      cfg_q  <= cfg_live;
      wait_q <= cfg_wait;
    end
  end

  xbus_phase_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (tmr_ld),
    .ld_val (tmr_val),
    .dec    (tmr_dec),
    .cnt    (tmr_cnt),
    .zero   (tmr_zero)
  );

  xbus_ad_path #(.AW(AW), .DW(DW)) u_ad (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld         (idle),
    .addr_in    (req_addr),
    .wdata_in   (req_wdata),
    .write_in   (req_write),
    .dsize      (cfg_q.dsize),
    .addr_phase ((state_q == XB_ALE) || (state_q == XB_ISO)),
    .data_phase (state_q == XB_CS),
    .cap        (cap),
    .ad_in      (bus_ad_in),
    .bus_addr   (bus_addr),
    .ad_out     (bus_ad_out),
    .ad_oe      (bus_ad_oe),
    .rdata      (rdata)
  );

  assign req_ready = idle;
  assign done      = (state_q == XB_RESP);
  assign err       = done & err_q;
  assign bus_cs_n  = ~(state_q == XB_CS);
  assign bus_ale   = (state_q == XB_ALE) ? cfg_q.ale_pol : ~cfg_q.ale_pol;

  // ---------------- assertions ----------------
  logic [CW-1:0] cs_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cs_run <= '0;
    else if (!bus_cs_n) cs_run <= cs_run + CW'(1);
    else               cs_run <= '0;
  end

  // R2: chip-select never outlasts the fixed floor plus the wait count
  a_r2_cs_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs_n |-> (cs_run <= {1'b0, wait_q} + CW'(1)));

  // R3: chip-select is never shorter than two clocks
  a_r3_cs_floor: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_cs_n) |=> !bus_cs_n);

  // R4: with acknowledge disabled, an unexpired wait period keeps CS low
  a_r4_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && !cfg_q.ack_en && !tmr_zero) |=> !bus_cs_n);

  // R5: multiplexed CS is preceded by an inactive-ALE isolation clock
  a_r5_iso_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_cs_n) && cfg_q.mux) |-> ($past(bus_ale) == ~cfg_q.ale_pol));

  // R7: non-multiplexed access asserts CS on the next clock
  a_r7_direct_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_en && !cfg_mux && cfg_dsize != XB_DSIZE_RSVD) |=> !bus_cs_n);

  // R8: a disabled chip-select rejects at once
  a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cfg_en) |=> (done && err && bus_cs_n));

  // R9: reserved size rejects with no bus activity
  a_r9_rsvd_size: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_en && cfg_dsize == XB_DSIZE_RSVD) |=> (done && err && bus_cs_n && !bus_ad_oe));

  // R11: done is a single-clock pulse and CS stays high around it
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && bus_cs_n));

endmodule

// File: tb/tb_xbus_cs_ctrl.sv
`timescale 1ns/1ps
module tb_xbus_cs_ctrl;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        cfg_en, cfg_mux, cfg_ale_pol, cfg_ack_en;
  logic [1:0]  cfg_ale_len, cfg_dsize;
  logic [3:0]  cfg_wait;
  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        req_ready, done, err;
  logic [31:0] rdata, bus_addr, bus_ad_out, bus_ad_in;
  logic        bus_cs_n, bus_ale, bus_ad_oe, bus_ack_n;

  xbus_cs_ctrl #(.AW(32), .DW(32), .WW(4)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_en(cfg_en), .cfg_mux(cfg_mux), .cfg_ale_pol(cfg_ale_pol),
    .cfg_ale_len(cfg_ale_len), .cfg_ack_en(cfg_ack_en), .cfg_dsize(cfg_dsize),
    .cfg_wait(cfg_wait),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .err(err),
    .rdata(rdata), .bus_cs_n(bus_cs_n), .bus_ale(bus_ale), .bus_addr(bus_addr),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .bus_ack_n(bus_ack_n)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  finished = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(input logic [1:0] ds, input logic [31:0] x);
    case (ds)
      2'b00:   return x & 32'h0000_00FF;
      2'b01:   return x & 32'h0000_FFFF;
      default: return x;
    endcase
  endfunction

  typedef struct packed {
    logic       mux;
    logic       pol;
    logic [1:0] alen;
    logic       acken;
    logic [4:0] ackat;
    logic [3:0] wt;
    logic [1:0] ds;
    logic       wr;
    logic [2:0] eale;
    logic [4:0] ecs;
  } vec_t;

  localparam int NV = 9;
  // ackat 31 = device never acknowledges
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 2'd0, 1'b0, 5'd31, 4'd4,  2'd3, 1'b0, 3'd0, 5'd6 },
    '{1'b0, 1'b1, 2'd0, 1'b1, 5'd2,  4'd4,  2'd3, 1'b0, 3'd0, 5'd3 },
    '{1'b0, 1'b1, 2'd0, 1'b0, 5'd0,  4'd4,  2'd3, 1'b0, 3'd0, 5'd6 },
    '{1'b0, 1'b1, 2'd0, 1'b1, 5'd0,  4'd5,  2'd0, 1'b0, 3'd0, 5'd2 },
    '{1'b1, 1'b1, 2'd0, 1'b0, 5'd31, 4'd1,  2'd0, 1'b1, 3'd1, 5'd3 },
    '{1'b1, 1'b0, 2'd3, 1'b1, 5'd1,  4'd2,  2'd1, 1'b0, 3'd4, 5'd2 },
    '{1'b1, 1'b1, 2'd2, 1'b0, 5'd31, 4'd15, 2'd1, 1'b1, 3'd3, 5'd17},
    '{1'b0, 1'b1, 2'd0, 1'b1, 5'd9,  4'd15, 2'd3, 1'b0, 3'd0, 5'd10},
    '{1'b0, 1'b1, 2'd0, 1'b1, 5'd7,  4'd4,  2'd1, 1'b1, 3'd0, 5'd6 }
  };

  localparam logic [31:0] AD_PATTERN = 32'hC3A5_9E71;

  task automatic run_txn(input vec_t v, input logic [31:0] a, input logic [31:0] wd,
                         input bit change_cfg, input string cs_tag);
    int ale_n = 0, iso_n = 0, cs_cnt = 0, first_cs = -1, k = 1;
    int addr_bad = 0, data_bad = 0, ready_bad = 0, abus_bad = 0;
    bit hung = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_en = 1'b1; cfg_mux = v.mux; cfg_ale_pol = v.pol; cfg_ale_len = v.alen;
    cfg_ack_en = v.acken; cfg_dsize = v.ds; cfg_wait = v.wt;
    req_valid = 1'b1; req_write = v.wr; req_addr = a; req_wdata = wd; bus_ack_n = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (change_cfg) begin cfg_wait = 4'hF; cfg_mux = ~cfg_mux; cfg_dsize = 2'b10; end
    forever begin
      if (req_ready) ready_bad++;
      if (bus_ale == v.pol) begin
        ale_n++;
        if (!(bus_ad_oe && bus_ad_out == a)) addr_bad++;
      end else if (v.mux && ale_n > 0 && first_cs < 0 && bus_cs_n && !done) begin
        iso_n++;
        if (!(bus_ad_oe && bus_ad_out == a)) addr_bad++;
      end
      if (!bus_cs_n) begin
        if (first_cs < 0) first_cs = k;
        if (bus_addr != a) abus_bad++;
        if (v.wr) begin
          if (!(bus_ad_oe && bus_ad_out == msk(v.ds, wd))) data_bad++;
        end else if (bus_ad_oe) data_bad++;
        bus_ack_n = (cs_cnt >= int'(v.ackat)) ? 1'b0 : 1'b1;
        cs_cnt++;
      end else begin
        bus_ack_n = 1'b1;
      end
      if (done) break;
      k++;
      if (k > 200) begin hung = 1; break; end
      @(negedge clk);
    end
    bus_ack_n = 1'b1;
    chk("R11", "no hang", 32'(hung), 32'd0);
    chk(cs_tag, "cs length", 32'(cs_cnt), 32'(v.ecs));
    chk(v.mux ? (v.pol ? "R5" : "R6") : "R7", "ale clocks", 32'(ale_n), 32'(v.eale));
    chk("R5", "isolation clocks", 32'(iso_n), 32'(v.eale));
    chk(v.mux ? "R5" : "R7", "cs latency", 32'(first_cs), 32'(1 + 2 * int'(v.eale)));
    chk("R5", "address drive errors", 32'(addr_bad), 32'd0);
    chk("R7", "address output errors", 32'(abus_bad), 32'd0);
    chk("R10", "data drive errors", 32'(data_bad), 32'd0);
    chk("R11", "cs high with done", 32'(bus_cs_n), 32'd1);
    chk("R11", "err on success", 32'(err), 32'd0);
    chk("R11", "ready during access", 32'(ready_bad), 32'd0);
    if (!v.wr) chk("R10", "read data", rdata, msk(v.ds, AD_PATTERN));
    @(negedge clk);
    chk("R11", "done width", 32'(done), 32'd0);
  endtask

  task automatic reject_txn(input logic en, input logic [1:0] ds, input string tag);
    int cs_seen = 0, oe_seen = 0, ale_seen = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_en = en; cfg_mux = 1'b1; cfg_ale_pol = 1'b1; cfg_ale_len = 2'd1;
    cfg_dsize = ds; cfg_wait = 4'd3; req_valid = 1'b1; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, "done after reject", 32'(done), 32'd1);
    chk(tag, "err after reject", 32'(err), 32'd1);
    for (int i = 0; i < 4; i++) begin
      if (!bus_cs_n) cs_seen++;
      if (bus_ad_oe) oe_seen++;
      if (bus_ale) ale_seen++;
      if (i < 3) @(negedge clk);
    end
    chk(tag, "cs clocks", 32'(cs_seen), 32'd0);
    chk(tag, "drive clocks", 32'(oe_seen), 32'd0);
    chk(tag, "ale clocks", 32'(ale_seen), 32'd0);
    chk(tag, "ready after reject", 32'(req_ready), 32'd1);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_en = 1'b0; cfg_mux = 1'b0; cfg_ale_pol = 1'b1; cfg_ale_len = 2'd0;
    cfg_ack_en = 1'b0; cfg_dsize = 2'b11; cfg_wait = 4'd0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    bus_ad_in = AD_PATTERN; bus_ack_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "cs_n in reset", 32'(bus_cs_n), 32'd1);
    chk("R1", "done in reset", 32'(done), 32'd0);
    chk("R1", "ready in reset", 32'(req_ready), 32'd1);
    chk("R1", "ale in reset", 32'(bus_ale), 32'd0);
    chk("R1", "oe in reset", 32'(bus_ad_oe), 32'd0);
    chk("R1", "rdata in reset", rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "err after reset", 32'(err), 32'd0);
    chk("R1", "cs_n after reset", 32'(bus_cs_n), 32'd1);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      string tag;
      if (v.acken && int'(v.ackat) <= int'(v.wt) + 1) tag = "R3";
      else if (!v.acken && v.ackat != 5'd31)           tag = "R4";
      else                                             tag = "R2";
      run_txn(v, 32'h4000_0100 + 32'(i * 4), 32'h1357_9BDF + 32'(i), 1'b0, tag);
    end

    // R8 disabled chip-select, R9 reserved size
    reject_txn(1'b0, 2'b11, "R8");
    reject_txn(1'b1, 2'b10, "R9");

    // R12 configuration frozen at acceptance (wait 3, non-multiplexed, 2-byte read)
    run_txn('{1'b0, 1'b1, 2'd0, 1'b0, 5'd31, 4'd3, 2'd1, 1'b0, 3'd0, 5'd5},
            32'h0000_BEE0, 32'h0, 1'b1, "R12");

    // R11 back-to-back accesses keep a CS-high clock between them
    run_txn(VECS[3], 32'h0000_0040, 32'h0, 1'b0, "R3");
    run_txn(VECS[3], 32'h0000_0044, 32'h0, 1'b0, "R3");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule